// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This unit takes one IEEE-754 operand, either binary32 or binary64, and turns it into a 32-bit or 64-bit integer. The destination can be signed or unsigned. A caller selects the source format, the destination form, a 2-bit rounding mode and a truncate override. One cycle later the unit returns the integer, zero-extended to the full output width, together with an invalid flag and an inexact flag. Both flags are valid only in the cycle where the result is valid.

The datapath has three stages of combinational logic. The first decodes the source fields into a common sign/exponent/significand form. The second aligns and rounds the magnitude. The third applies the special-value rules and clamps to the limits of the chosen destination. A single output register closes the path. Two rules set this unit apart from a plain conversion. Unsigned destinations test the sign before any rounding, so every negative nonzero input is rejected even if it would round to zero. Signed destinations map every NaN to all ones.

Top module: `f2i_conv_unit`

## Requirements
- R1: `in_dbl`=0 selects binary32 taken from `in_operand[31:0]`, and `in_dbl`=1 selects binary64 from all 64 bits. `in_wide`=0/1 selects a 32/64-bit destination and `in_signed`=1 selects two's complement. Exactly representable values convert exactly with no flags.
- R2: `in_rmode` selects the rounding: 2'b00 nearest with ties to even, 2'b01 toward zero, 2'b10 toward minus infinity, 2'b11 toward plus infinity.
- R3: With `in_chop`=1 the rounding is toward zero whatever `in_rmode` holds.
- R4: For an unsigned destination, a negative, nonzero, non-NaN input (tiny values and minus infinity included) gives 0 with invalid=1 and inexact=0, in every rounding mode and with or without chop.
- R5: For a signed destination, any NaN gives all ones at the destination width with invalid=1.
- R6: For an unsigned destination a NaN gives all ones at the destination width. Plus infinity gives the destination maximum, and minus infinity into a signed destination gives the most negative value. Each of these raises invalid.
- R7: A finite value whose rounded magnitude exceeds the destination range saturates to the maximum, or for signed negative values to the minimum, whose magnitude is one above the maximum. Invalid is raised and inexact is held low. An overflow caused only by rounding up counts too.
- R8: Inexact=1 exactly when a non-saturated finite conversion discards nonzero fraction bits. Zeros of either sign give 0 with no flags. Subnormals round as nonzero values below one half.
- R9: A 32-bit destination leaves `out_result[63:32]` at zero, and negative results appear there as 32-bit two's complement. For binary32 sources, `in_operand[63:32]` has no effect.
- R10: Result and flags are registered. `out_valid` is high in exactly the cycle after each `in_valid` cycle. The flags are low whenever `out_valid` is low. Synchronous active-high `rst` clears `out_valid`, the flags and the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and controls present this cycle |
| in_dbl | input | 1 | 1 = binary64 source, 0 = binary32 in bits 31:0 |
| in_operand | input | 64 | Source operand bits |
| in_wide | input | 1 | 1 = 64-bit destination, 0 = 32-bit |
| in_signed | input | 1 | 1 = signed destination |
| in_chop | input | 1 | Force rounding toward zero |
| in_rmode | input | 2 | Rounding mode selector |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 64 | Integer result, zero-extended |
| out_invalid | output | 1 | Invalid-operation flag pulse |
| out_inexact | output | 1 | Inexact flag pulse |

## Verification
Some properties are checked on every cycle:
- the one-cycle valid pulse;
- flags being quiet outside valid cycles, and invalid and inexact never being raised together;
- the zeroed upper half for narrow destinations;
- negative-to-unsigned rejection and NaN-to-signed all-ones, both decoded straight from the operand port.

Other behaviours depend on the numeric value of the result, and only the bench's chosen vectors can show them. These are rounding direction and ties to even, the chop override, saturation limits (including overflow created by rounding up), subnormal handling and the signed minimum boundary.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

   localparam int SP_EXP_W  = 8;
   localparam int SP_FRAC_W = 23;
   localparam int DP_EXP_W  = 11;
   localparam int DP_FRAC_W = 52;
   localparam int OPND_W    = DP_EXP_W + DP_FRAC_W + 1;
   localparam int SIG_W     = DP_FRAC_W + 1;
   localparam int EXP_W     = DP_EXP_W + 2;

   typedef enum logic [1:0] {
      RND_NEAREST = 2'b00,
      RND_ZERO    = 2'b01,
      RND_DOWN    = 2'b10,
      RND_UP      = 2'b11
   } rnd_mode_e;

   typedef struct packed {
      logic                    sign;
      logic                    is_nan;
      logic                    is_inf;
      logic                    is_zero;
      logic signed [EXP_W-1:0] exp;
      logic [SIG_W-1:0]        sig;
   } fp_unpacked_t;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
   import f2i_pkg::*;
#(
   parameter int FLD_EXP_W  = 8,
   parameter int FLD_FRAC_W = 23
) (
   input  logic [FLD_EXP_W+FLD_FRAC_W:0] fp_bits,
   output fp_unpacked_t                  unp
);
   localparam int BIAS = (1 << (FLD_EXP_W - 1)) - 1;
   localparam int PAD  = SIG_W - 1 - FLD_FRAC_W;

   if (PAD < 0) begin : g_bad_frac
      $error("f2i_unpack: fraction wider than common significand");
   end
   if (FLD_EXP_W + 2 > EXP_W) begin : g_bad_exp
      $error("f2i_unpack: exponent wider than common exponent");
   end

   logic [FLD_EXP_W-1:0]  exp_fld;
   logic [FLD_FRAC_W-1:0] frac_fld;
   logic                  exp_all_one;
   logic                  exp_all_zero;
   logic                  frac_nz;

   assign exp_fld      = fp_bits[FLD_FRAC_W +: FLD_EXP_W];
   assign frac_fld     = fp_bits[FLD_FRAC_W-1:0];
   assign exp_all_one  = &exp_fld;
   assign exp_all_zero = ~|exp_fld;
   assign frac_nz      = |frac_fld;

   always_comb begin
      unp.sign    = fp_bits[FLD_EXP_W+FLD_FRAC_W];
      unp.is_nan  = exp_all_one & frac_nz;
      unp.is_inf  = exp_all_one & ~frac_nz;
      unp.is_zero = exp_all_zero & ~frac_nz;
      unp.exp     = exp_all_zero ? EXP_W'(1 - BIAS)
                                 : EXP_W'(int'(exp_fld) - BIAS);
      unp.sig     = SIG_W'({~exp_all_zero, frac_fld}) << PAD;
   end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
   import f2i_pkg::*;
#(
   parameter int INT_W = 64
) (
   input  logic                    sign,
   input  logic signed [EXP_W-1:0] exp,
   input  logic [SIG_W-1:0]        sig,
   input  rnd_mode_e               mode,
   output logic [INT_W:0]          mag,
   output logic                    huge,
   output logic                    lost
);
   localparam int FX_W = 2 * INT_W;
   localparam int SH_W = $clog2(FX_W);
   localparam logic signed [EXP_W-1:0] SH_OFS   = EXP_W'(INT_W - (SIG_W - 1));
   localparam logic signed [EXP_W-1:0] HUGE_LIM = EXP_W'(INT_W - 1);

   logic signed [EXP_W-1:0] sh_s;
   logic                    tiny;
   logic [SH_W-1:0]         sh_amt;
   logic [FX_W-1:0]         fx;
   logic [INT_W-1:0]        int_part;
   logic                    guard;
   logic                    sticky;
   logic                    bump;

   always_comb begin
      sh_s     = exp + SH_OFS;
      huge     = exp > HUGE_LIM;
      tiny     = sh_s < 0;
      sh_amt   = (tiny || huge) ? '0 : sh_s[SH_W-1:0];
      fx       = FX_W'(sig) << sh_amt;
      int_part = tiny ? '0 : fx[FX_W-1:INT_W];
      guard    = tiny ? 1'b0 : fx[INT_W-1];
      sticky   = tiny ? |sig : |fx[INT_W-2:0];
      lost     = guard | sticky;
      unique case (mode)
         RND_NEAREST: bump = guard & (sticky | int_part[0]);
         RND_ZERO:    bump = 1'b0;
         RND_DOWN:    bump = lost & sign;
         RND_UP:      bump = lost & ~sign;
         default:     bump = 1'b0;
      endcase
      mag = {1'b0, int_part} + (INT_W+1)'(bump);
   end
endmodule

// File: rtl/f2i_limit.sv
module f2i_limit #(
   parameter int NARROW_W = 32,
   parameter int INT_W    = 64
) (
   input  logic             sign,
   input  logic             is_nan,
   input  logic             is_inf,
   input  logic             is_zero,
   input  logic [INT_W:0]   mag,
   input  logic             huge,
   input  logic             lost,
   input  logic             dst_wide,
   input  logic             dst_signed,
   output logic [INT_W-1:0] result,
   output logic             invalid,
   output logic             inexact
);
   localparam int N_DST = 2;

   logic [INT_W-1:0] res_a [N_DST];
   logic             inv_a [N_DST];
   logic             inx_a [N_DST];

   for (genvar g = 0; g < N_DST; g++) begin : g_dst
      localparam int W = (g == 0) ? NARROW_W : INT_W;
      localparam logic [INT_W:0]   UMAX  = ((INT_W+1)'(1) << W) - (INT_W+1)'(1);
      localparam logic [INT_W:0]   SPOS  = ((INT_W+1)'(1) << (W-1)) - (INT_W+1)'(1);
      localparam logic [INT_W:0]   SNEG  = (INT_W+1)'(1) << (W-1);
      localparam logic [INT_W-1:0] WMASK = UMAX[INT_W-1:0];
      localparam logic [INT_W-1:0] MINV  = SNEG[INT_W-1:0];

      logic [INT_W:0]   lim;
      logic             ovf;
      logic [INT_W-1:0] maxv;
      logic [INT_W-1:0] negv;
      logic [INT_W-1:0] r;
      logic             inv;
      logic             inx;

      always_comb begin
         lim  = dst_signed ? (sign ? SNEG : SPOS) : UMAX;
         ovf  = huge | (mag > lim);
         maxv = dst_signed ? SPOS[INT_W-1:0] : WMASK;
         negv = (INT_W'(0) - mag[INT_W-1:0]) & WMASK;
         r    = '0;
         inv  = 1'b0;
         inx  = 1'b0;
         if (is_nan) begin
            r   = WMASK;
            inv = 1'b1;
         end else if (!dst_signed && sign && !is_zero) begin
            inv = 1'b1;
         end else if (is_zero) begin
            r = '0;
         end else if (is_inf || ovf) begin
            r   = sign ? MINV : maxv;
            inv = 1'b1;
         end else begin
            r   = sign ? negv : (mag[INT_W-1:0] & WMASK);
            inx = lost;
         end
      end

      assign res_a[g] = r;
      assign inv_a[g] = inv;
      assign inx_a[g] = inx;
   end

   assign result  = dst_wide ? res_a[1] : res_a[0];
   assign invalid = dst_wide ? inv_a[1] : inv_a[0];
   assign inexact = dst_wide ? inx_a[1] : inx_a[0];
endmodule

// File: rtl/f2i_conv_unit.sv
module f2i_conv_unit
   import f2i_pkg::*;
#(
   parameter int NARROW_W = 32,
   parameter int WIDE_W   = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_dbl,
   input  logic [OPND_W-1:0] in_operand,
   input  logic              in_wide,
   input  logic              in_signed,
   input  logic              in_chop,
   input  logic [1:0]        in_rmode,
   output logic              out_valid,
   output logic [WIDE_W-1:0] out_result,
   output logic              out_invalid,
   output logic              out_inexact
);
   localparam int SP_W = SP_EXP_W + SP_FRAC_W + 1;

   if (NARROW_W < 2 || NARROW_W >= WIDE_W) begin : g_bad_narrow
      $error("f2i_conv_unit: NARROW_W must lie in [2, WIDE_W)");
   end
   if (WIDE_W < SIG_W) begin : g_bad_wide
      $error("f2i_conv_unit: WIDE_W must cover the binary64 significand");
   end

   fp_unpacked_t      u_sp;
   fp_unpacked_t      u_dp;
   fp_unpacked_t      u_sel;
   rnd_mode_e         mode_eff;
   logic [WIDE_W:0]   mag;
   logic              huge;
   logic              lost;
   logic [WIDE_W-1:0] res_c;
   logic              inv_c;
   logic              inx_c;

   f2i_unpack #(.FLD_EXP_W(SP_EXP_W), .FLD_FRAC_W(SP_FRAC_W)) u_unp_sp (
      .fp_bits (in_operand[SP_W-1:0]),
      .unp     (u_sp)
   );

   f2i_unpack #(.FLD_EXP_W(DP_EXP_W), .FLD_FRAC_W(DP_FRAC_W)) u_unp_dp (
      .fp_bits (in_operand),
      .unp     (u_dp)
   );

   assign u_sel    = in_dbl ? u_dp : u_sp;
   assign mode_eff = in_chop ? RND_ZERO : rnd_mode_e'(in_rmode);

   f2i_round #(.INT_W(WIDE_W)) u_round (
      .sign (u_sel.sign),
      .exp  (u_sel.exp),
      .sig  (u_sel.sig),
      .mode (mode_eff),
      .mag  (mag),
      .huge (huge),
      .lost (lost)
   );

   f2i_limit #(.NARROW_W(NARROW_W), .INT_W(WIDE_W)) u_limit (
      .sign       (u_sel.sign),
      .is_nan     (u_sel.is_nan),
      .is_inf     (u_sel.is_inf),
      .is_zero    (u_sel.is_zero),
      .mag        (mag),
      .huge       (huge),
      .lost       (lost),
      .dst_wide   (in_wide),
      .dst_signed (in_signed),
      .result     (res_c),
      .invalid    (inv_c),
      .inexact    (inx_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_invalid <= 1'b0;
         out_inexact <= 1'b0;
         out_result  <= '0;
      end else begin
         out_valid   <= in_valid;
         out_invalid <= in_valid & inv_c;
         out_inexact <= in_valid & inx_c;
         if (in_valid) begin
            out_result <= res_c;
         end
      end
   end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
   parameter int NARROW_W = 32,
   parameter int WIDE_W   = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_dbl,
   input logic [63:0]       in_operand,
   input logic              in_wide,
   input logic              in_signed,
   input logic              out_valid,
   input logic [WIDE_W-1:0] out_result,
   input logic              out_invalid,
   input logic              out_inexact
);
   localparam logic [WIDE_W-1:0] ONES_N = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   logic op_nan;
   logic op_zero;
   logic op_neg;

   always_comb begin
      if (in_dbl) begin
         op_nan  = (&in_operand[62:52]) & (|in_operand[51:0]);
         op_zero = ~|in_operand[62:0];
         op_neg  = in_operand[63];
      end else begin
         op_nan  = (&in_operand[30:23]) & (|in_operand[22:0]);
         op_zero = ~|in_operand[30:0];
         op_neg  = in_operand[31];
      end
   end

   // R10
   valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R10
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R10
   quiet_flags_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (!out_invalid && !out_inexact));

   // R7
   flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !(out_invalid && out_inexact));

   // R9
   narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_wide) |=> (out_result[WIDE_W-1:NARROW_W] == '0));

   // R4
   neg_unsigned_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_signed && op_neg && !op_nan && !op_zero)
      |=> (out_result == '0 && out_invalid && !out_inexact));

   // R5
   nan_signed_wide_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_signed && in_wide && op_nan)
      |=> (out_result == '1 && out_invalid));

   // R5
   nan_signed_narrow_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_signed && !in_wide && op_nan)
      |=> (out_result == ONES_N && out_invalid));
endmodule

bind f2i_conv_unit f2i_conv_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .in_dbl      (in_dbl),
   .in_operand  (in_operand),
   .in_wide     (in_wide),
   .in_signed   (in_signed),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_invalid (out_invalid),
   .out_inexact (out_inexact)
);

// File: tb/f2i_conv_unit_tb_top.sv
module f2i_conv_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYC = 20000;

   localparam logic [63:0] N32  = 64'h0000_0000_FFFF_FFFF;
   localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam logic [1:0]  RNE = 2'b00, RZ = 2'b01, DN = 2'b10, UP = 2'b11;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_dbl = 1'b0;
   logic [63:0] in_operand = '0;
   logic        in_wide = 1'b0;
   logic        in_signed = 1'b0;
   logic        in_chop = 1'b0;
   logic [1:0]  in_rmode = 2'b00;
   logic        out_valid;
   logic [63:0] out_result;
   logic        out_invalid;
   logic        out_inexact;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      string       tag;
      logic [63:0] res;
      logic        inv;
      logic        inx;
   } exp_t;

   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   f2i_conv_unit dut_i (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .in_dbl      (in_dbl),
      .in_operand  (in_operand),
      .in_wide     (in_wide),
      .in_signed   (in_signed),
      .in_chop     (in_chop),
      .in_rmode    (in_rmode),
      .out_valid   (out_valid),
      .out_result  (out_result),
      .out_invalid (out_invalid),
      .out_inexact (out_inexact)
   );

   task automatic apply(input string tag, input bit dbl, input bit wide, input bit sgn,
                        input bit chop, input logic [1:0] rm, input logic [63:0] op,
                        input logic [63:0] res, input bit inv, input bit inx);
      exp_t e;
      @(negedge clk);
      in_dbl     = dbl;
      in_wide    = wide;
      in_signed  = sgn;
      in_chop    = chop;
      in_rmode   = rm;
      in_operand = op;
      in_valid   = 1'b1;
      e.tag = tag;
      e.res = res;
      e.inv = inv;
      e.inx = inx;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Monitor: compares every valid output with the front of the scoreboard
   always @(negedge clk) begin
      exp_t e;
      if (!rst && out_valid) begin
         checks++;
         if (sb.size() == 0) begin
            fails++;
            $display("FAIL R10 unexpected out_valid: actual 1 expected 0");
         end else begin
            e = sb.pop_front();
            if (out_result !== e.res || out_invalid !== e.inv || out_inexact !== e.inx) begin
               fails++;
               $display("FAIL %s: actual res=%h inv=%b inx=%b expected res=%h inv=%b inx=%b",
                        e.tag, out_result, out_invalid, out_inexact, e.res, e.inv, e.inx);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG_CYC);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      checks++;
      if (out_valid !== 1'b0 || out_result !== '0 || out_invalid !== 1'b0 || out_inexact !== 1'b0) begin
         fails++;
         $display("FAIL R10 reset: actual v=%b res=%h inv=%b inx=%b expected all zero",
                  out_valid, out_result, out_invalid, out_inexact);
      end
      rst = 1'b0;
      idle(2);

      // R1 exact conversions
      apply("R1 sp 3.0 u64",      0, 1, 0, 0, RNE, 64'h4040_0000, 64'd3, 0, 0);
      apply("R1 dp 2^32 s64",     1, 1, 1, 0, RNE, 64'h41F0_0000_0000_0000, 64'h1_0000_0000, 0, 0);
      apply("R1 R7 sp -2^31 s32", 0, 0, 1, 0, RNE, 64'hCF00_0000, 64'h8000_0000, 0, 0);
      // R2 rounding modes
      apply("R2 sp 1.5 rne",      0, 0, 1, 0, RNE, 64'h3FC0_0000, 64'd2, 0, 1);
      apply("R2 sp 2.5 rne tie",  0, 0, 1, 0, RNE, 64'h4020_0000, 64'd2, 0, 1);
      apply("R2 sp 2.5 up",       0, 0, 1, 0, UP,  64'h4020_0000, 64'd3, 0, 1);
      apply("R2 sp 2.5 down",     0, 0, 1, 0, DN,  64'h4020_0000, 64'd2, 0, 1);
      apply("R2 sp 2.5 rz",       0, 0, 1, 0, RZ,  64'h4020_0000, 64'd2, 0, 1);
      apply("R2 R9 sp -2.5 rne",  0, 0, 1, 0, RNE, 64'hC020_0000, 64'hFFFF_FFFE, 0, 1);
      apply("R2 sp -2.5 down",    0, 0, 1, 0, DN,  64'hC020_0000, 64'hFFFF_FFFD, 0, 1);
      apply("R2 sp -2.5 up",      0, 0, 1, 0, UP,  64'hC020_0000, 64'hFFFF_FFFE, 0, 1);
      apply("R2 dp 123.75 rne",   1, 1, 1, 0, RNE, 64'h405E_F000_0000_0000, 64'd124, 0, 1);
      apply("R2 dp 123.75 down",  1, 1, 1, 0, DN,  64'h405E_F000_0000_0000, 64'd123, 0, 1);
      apply("R2 dp 123.75 u32 up",1, 0, 0, 0, UP,  64'h405E_F000_0000_0000, 64'd124, 0, 1);
      apply("R2 dp 0.5 rne",      1, 1, 1, 0, RNE, 64'h3FE0_0000_0000_0000, 64'd0, 0, 1);
      apply("R2 dp 0.5 up",       1, 1, 1, 0, UP,  64'h3FE0_0000_0000_0000, 64'd1, 0, 1);
      // R3 chop override
      apply("R3 sp 2.5 chop/up",  0, 0, 1, 1, UP,  64'h4020_0000, 64'd2, 0, 1);
      apply("R3 sp -2.5 chop/dn", 0, 0, 1, 1, DN,  64'hC020_0000, 64'hFFFF_FFFE, 0, 1);
      apply("R3 dp 123.75 chop",  1, 1, 0, 1, RNE, 64'h405E_F000_0000_0000, 64'd123, 0, 1);
      idle(3);
      // R10 quiet gap
      checks++;
      if (out_valid !== 1'b0 || out_invalid !== 1'b0 || out_inexact !== 1'b0) begin
         fails++;
         $display("FAIL R10 idle gap: actual v=%b inv=%b inx=%b expected 0 0 0",
                  out_valid, out_invalid, out_inexact);
      end
      // R4 negative into unsigned
      apply("R4 sp tiny neg u32",   0, 0, 0, 0, RNE, 64'hAB98_FBA8, 64'd0, 1, 0);
      apply("R4 sp tiny neg u64",   0, 1, 0, 0, UP,  64'hAB98_FBA8, 64'd0, 1, 0);
      apply("R4 sp tiny neg chop",  0, 0, 0, 1, RNE, 64'hAB98_FBA8, 64'd0, 1, 0);
      apply("R4 dp tiny neg u32",   1, 0, 0, 0, RNE, 64'hBD73_1F75_0000_0000, 64'd0, 1, 0);
      apply("R4 dp tiny neg u64dn", 1, 1, 0, 0, DN,  64'hBD73_1F75_0000_0000, 64'd0, 1, 0);
      apply("R4 sp -2.5 u64",       0, 1, 0, 0, RNE, 64'hC020_0000, 64'd0, 1, 0);
      // R5 NaN into signed
      apply("R5 sp nan s32",        0, 0, 1, 0, RNE, 64'h7FC0_0000, N32, 1, 0);
      apply("R5 sp nan s64 chop",   0, 1, 1, 1, RNE, 64'h7FC0_0000, ALL1, 1, 0);
      apply("R5 dp nan s64",        1, 1, 1, 0, RNE, 64'h7FF8_0000_0000_0000, ALL1, 1, 0);
      apply("R5 dp nan s32",        1, 0, 1, 0, UP,  64'h7FF8_0000_0000_0000, N32, 1, 0);
      // R6 other specials
      apply("R6 sp nan u32",        0, 0, 0, 0, RNE, 64'h7FC0_0000, N32, 1, 0);
      apply("R6 dp nan u64",        1, 1, 0, 0, RNE, 64'h7FF8_0000_0000_0000, ALL1, 1, 0);
      apply("R6 sp +inf s32",       0, 0, 1, 0, RNE, 64'h7F80_0000, 64'h7FFF_FFFF, 1, 0);
      apply("R6 sp +inf u64",       0, 1, 0, 0, RNE, 64'h7F80_0000, ALL1, 1, 0);
      apply("R6 dp -inf s64",       1, 1, 1, 0, RNE, 64'hFFF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1, 0);
      apply("R6 dp -inf u32",       1, 0, 0, 0, RNE, 64'hFFF0_0000_0000_0000, 64'd0, 1, 0);
      // R7 saturation
      apply("R7 sp 2^32 u32",       0, 0, 0, 0, RNE, 64'h4F80_0000, N32, 1, 0);
      apply("R7 sp 2^31 s32",       0, 0, 1, 0, RNE, 64'h4F00_0000, 64'h7FFF_FFFF, 1, 0);
      apply("R7 sp -2^32 s32",      0, 0, 1, 0, RNE, 64'hCF80_0000, 64'h8000_0000, 1, 0);
      apply("R7 dp round ovf u32",  1, 0, 0, 0, RNE, 64'h41EF_FFFF_FFF0_0000, N32, 1, 0);
      apply("R7 R8 dp no ovf rz",   1, 0, 0, 0, RZ,  64'h41EF_FFFF_FFF0_0000, N32, 0, 1);
      apply("R7 dp 2^63 s64",       1, 1, 1, 0, RNE, 64'h43E0_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1, 0);
      apply("R7 dp 2^63 u64",       1, 1, 0, 0, RNE, 64'h43E0_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0);
      apply("R7 dp -2^63 s64",      1, 1, 1, 0, RNE, 64'hC3E0_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0);
      apply("R7 dp 2^64 u64",       1, 1, 0, 0, RNE, 64'h43F0_0000_0000_0000, ALL1, 1, 0);
      // R8 zeros and subnormals
      apply("R8 sp +0 up",          0, 0, 1, 0, UP,  64'h0000_0000, 64'd0, 0, 0);
      apply("R8 sp -0 u32",         0, 0, 0, 0, RNE, 64'h8000_0000, 64'd0, 0, 0);
      apply("R8 sp subn up",        0, 0, 0, 0, UP,  64'h0000_0001, 64'd1, 0, 1);
      apply("R8 sp subn rne",       0, 0, 0, 0, RNE, 64'h0000_0001, 64'd0, 0, 1);
      apply("R8 sp -subn down",     0, 0, 1, 0, DN,  64'h8000_0001, N32, 0, 1);
      // R9 upper operand bits ignored for binary32
      apply("R9 sp hi garbage",     0, 1, 1, 0, RNE, 64'hDEAD_BEEF_3FC0_0000, 64'd2, 0, 1);
      idle(4);

      // R10 every applied vector produced exactly one result
      checks++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R10 pending results: actual %0d expected 0", sb.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule